// File: doc/BRIEF.md
# Translation Lookaside Buffer with Access Rights and Usage Tracking

This block is a small, fully associative cache of address translations for a 4 KB page size. Each cycle it can take one lookup: it compares the page number of a virtual address and the current process identifier against every stored entry. In the same cycle it returns one of three results: a hit with the physical address, a miss fault, or a permission fault. A miss never starts a refill. Software services it and installs the translation through the maintenance command port.

Each entry holds a read right and a write right, a touched flag and a dirty flag. A successful access sets the touched flag, which gives software a coarse recency measure for choosing pages to replace. A successful write also sets the dirty flag, which marks a page that must be written back before eviction. The flags of the matched entry are returned with every hit, as they stood before that access. Maintenance commands are fill, invalidate one slot, flush all slots and clear all touched flags. They take effect only while the privileged-mode input is high.

Top module: `xlate_cache`

## Requirements
- R1: A lookup whose page number (virtual address bits [31:12]) and process id both match a valid entry, and whose access kind that entry permits, asserts `hit` in the same cycle and drives `paddr` with the entry's frame number followed by virtual address bits [11:0].
- R2: A lookup that matches no valid entry asserts `fault_miss` with `hit` low, and leaves every entry unchanged.
- R3: An entry whose page number matches but whose process id differs from `cur_pid` is not a match.
- R4: On a match, a read (`lk_write`=0) without the read right or a write (`lk_write`=1) without the write right asserts `fault_perm` with `hit` low, and does not change the entry's touched or dirty flags.
- R5: A hit sets the entry's touched flag. `hit_touched` and `hit_dirty` report the flags as they were before the current access.
- R6: A write hit sets the entry's dirty flag. A read hit leaves the dirty flag unchanged.
- R7: A command (`cmd_valid`=1) while `priv_mode`=0 raises `cmd_priv_fault` in the same cycle and changes no entry.
- R8: A privileged fill (`cmd_op`=2'b00) writes slot `cmd_idx` with the given page, frame, process id and rights. It marks the slot valid and clears its touched and dirty flags.
- R9: A privileged invalidate (`cmd_op`=2'b01) clears the valid flag of slot `cmd_idx` only.
- R10: A privileged flush (`cmd_op`=2'b10) clears the valid flag of every slot.
- R11: A privileged clear-touched (`cmd_op`=2'b11) clears every touched flag in one cycle and keeps the dirty flags.
- R12: After reset every slot is invalid, so every lookup misses.
- R13: When more than one valid entry matches, the lowest-numbered slot supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| lk_vaddr | input | 32 | Virtual address to translate |
| cur_pid | input | 8 | Process id of the running task |
| hit | output | 1 | Translation succeeded |
| paddr | output | 32 | Physical address, valid with hit |
| fault_miss | output | 1 | No matching valid entry |
| fault_perm | output | 1 | Matching entry denies the access kind |
| hit_touched | output | 1 | Touched flag of matched entry before this access |
| hit_dirty | output | 1 | Dirty flag of matched entry before this access |
| priv_mode | input | 1 | Processor is in privileged mode |
| cmd_valid | input | 1 | Maintenance command request |
| cmd_op | input | 2 | 00 fill, 01 invalidate, 10 flush, 11 clear touched |
| cmd_idx | input | 3 | Target slot for fill and invalidate |
| cmd_vpn | input | 20 | Page number to install |
| cmd_pfn | input | 20 | Frame number to install |
| cmd_pid | input | 8 | Process id to install |
| cmd_rd | input | 1 | Read right to install |
| cmd_wr | input | 1 | Write right to install |
| cmd_priv_fault | output | 1 | Command refused in user mode |

## Verification
Lookups are tried against an address that is present, one whose page matches under a foreign process id, and one that is absent. Together these separate the tag compare from the process-id compare. Entries with only one of the two rights are probed with both access kinds, which shows that the right is chosen by access direction and that a refused access leaves no trace in the flags. Repeated reads and writes to one entry, followed by clear-touched, show that touched, dirty and the pre-access reporting are independent. Two slots holding the same page show the priority order, and invalidating them one at a time shows it again.

// File: rtl/xc_pkg.sv
package xc_pkg;
    parameter int VPN_W = 20;
    parameter int PFN_W = 20;
    parameter int PID_W = 8;
    parameter int OFF_W = 12;
    localparam int VA_W = VPN_W + OFF_W;
    localparam int PA_W = PFN_W + OFF_W;

    typedef enum logic [1:0] {
        OP_FILL  = 2'b00,
        OP_INVAL = 2'b01,
        OP_FLUSH = 2'b10,
        OP_CLRT  = 2'b11
    } cmd_op_e;

    typedef struct packed {
        logic             valid;
        logic [PID_W-1:0] pid;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
        logic             rd;
        logic             wr;
        logic             touched;
        logic             dirty;
    } xc_entry_t;
endpackage

// File: rtl/xc_match.sv
module xc_match
    import xc_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  xc_entry_t [ENTRIES-1:0] tbl,
    input  logic [VPN_W-1:0]        vpn,
    input  logic [PID_W-1:0]        pid,
    output logic [ENTRIES-1:0]      match
);
    // one comparator per slot
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = tbl[g].valid && (tbl[g].vpn == vpn) && (tbl[g].pid == pid);
    end
endmodule

// File: rtl/xc_pick.sv
module xc_pick #(
    parameter int ENTRIES = 8,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] match,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);
    // lowest index wins: scan from the top down so the last write is the lowest
    always_comb begin
        found = |match;
        idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/xc_table.sv
module xc_table
    import xc_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_ok,
    input  logic                    acc_wr,
    input  logic [IDX_W-1:0]        acc_idx,
    input  logic                    cmd_go,
    input  cmd_op_e                 cmd_op,
    input  logic [IDX_W-1:0]        cmd_idx,
    input  logic [VPN_W-1:0]        cmd_vpn,
    input  logic [PFN_W-1:0]        cmd_pfn,
    input  logic [PID_W-1:0]        cmd_pid,
    input  logic                    cmd_rd,
    input  logic                    cmd_wr,
    output xc_entry_t [ENTRIES-1:0] tbl
);
    typedef struct packed {
        xc_entry_t [ENTRIES-1:0] ent;
    } tbl_state_t;

    tbl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // access side effects first; a same-cycle command overrides them
        if (acc_ok) begin
            st_d.ent[acc_idx].touched = 1'b1;
            if (acc_wr) st_d.ent[acc_idx].dirty = 1'b1;
        end
        if (cmd_go) begin
            unique case (cmd_op)
                OP_FILL: begin
                    st_d.ent[cmd_idx].valid   = 1'b1;
                    st_d.ent[cmd_idx].pid     = cmd_pid;
                    st_d.ent[cmd_idx].vpn     = cmd_vpn;
                    st_d.ent[cmd_idx].pfn     = cmd_pfn;
                    st_d.ent[cmd_idx].rd      = cmd_rd;
                    st_d.ent[cmd_idx].wr      = cmd_wr;
                    st_d.ent[cmd_idx].touched = 1'b0;
                    st_d.ent[cmd_idx].dirty   = 1'b0;
                end
                OP_INVAL: st_d.ent[cmd_idx].valid = 1'b0;
                OP_FLUSH: begin
                    for (int i = 0; i < ENTRIES; i++) st_d.ent[i].valid = 1'b0;
                end
                OP_CLRT: begin
                    for (int i = 0; i < ENTRIES; i++) st_d.ent[i].touched = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tbl = st_q.ent;
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
    import xc_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic             lk_write,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic [PID_W-1:0] cur_pid,
    output logic             hit,
    output logic [PA_W-1:0]  paddr,
    output logic             fault_miss,
    output logic             fault_perm,
    output logic             hit_touched,
    output logic             hit_dirty,
    input  logic             priv_mode,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [IDX_W-1:0] cmd_idx,
    input  logic [VPN_W-1:0] cmd_vpn,
    input  logic [PFN_W-1:0] cmd_pfn,
    input  logic [PID_W-1:0] cmd_pid,
    input  logic             cmd_rd,
    input  logic             cmd_wr,
    output logic             cmd_priv_fault
);
    xc_entry_t [ENTRIES-1:0] tbl;
    logic [ENTRIES-1:0]      match;
    logic                    found;
    logic [IDX_W-1:0]        sel_idx;
    xc_entry_t               sel;
    logic                    allowed;
    logic                    cmd_go;
    logic [ENTRIES-1:0]      valid_vec, touched_vec, dirty_vec;

    xc_match #(.ENTRIES(ENTRIES)) u_match (
        .tbl   (tbl),
        .vpn   (lk_vaddr[VA_W-1:OFF_W]),
        .pid   (cur_pid),
        .match (match)
    );

    xc_pick #(.ENTRIES(ENTRIES)) u_pick (
        .match (match),
        .found (found),
        .idx   (sel_idx)
    );

    assign cmd_go = cmd_valid && priv_mode;

    xc_table #(.ENTRIES(ENTRIES)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_ok  (hit),
        .acc_wr  (lk_write),
        .acc_idx (sel_idx),
        .cmd_go  (cmd_go),
        .cmd_op  (cmd_op_e'(cmd_op)),
        .cmd_idx (cmd_idx),
        .cmd_vpn (cmd_vpn),
        .cmd_pfn (cmd_pfn),
        .cmd_pid (cmd_pid),
        .cmd_rd  (cmd_rd),
        .cmd_wr  (cmd_wr),
        .tbl     (tbl)
    );

    always_comb begin
        sel            = tbl[sel_idx];
        allowed        = lk_write ? sel.wr : sel.rd;
        hit            = lk_valid && found && allowed;
        fault_miss     = lk_valid && !found;
        fault_perm     = lk_valid && found && !allowed;
        paddr          = hit ? {sel.pfn, lk_vaddr[OFF_W-1:0]} : '0;
        hit_touched    = hit && sel.touched;
        hit_dirty      = hit && sel.dirty;
        cmd_priv_fault = cmd_valid && !priv_mode;
        for (int i = 0; i < ENTRIES; i++) begin
            valid_vec[i]   = tbl[i].valid;
            touched_vec[i] = tbl[i].touched;
            dirty_vec[i]   = tbl[i].dirty;
        end
    end
endmodule

// File: rtl/xc_cache_chk.sv
module xc_cache_chk #(
    parameter int ENTRIES = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic               lk_write,
    input logic               hit,
    input logic               fault_miss,
    input logic               fault_perm,
    input logic               cmd_valid,
    input logic               priv_mode,
    input logic [1:0]         cmd_op,
    input logic [ENTRIES-1:0] valid_vec,
    input logic [ENTRIES-1:0] touched_vec,
    input logic [ENTRIES-1:0] dirty_vec
);
    // R2
    outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit, fault_miss, fault_perm}));

    // R1
    hit_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> lk_valid);

    // R7
    user_cmd_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !priv_mode) |=> $stable(valid_vec));

    // R10
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && priv_mode && cmd_op == 2'b10) |=> (valid_vec == '0));

    // R11
    clr_touched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && priv_mode && cmd_op == 2'b11) |=> (touched_vec == '0));

    // R6
    write_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && lk_write && !cmd_valid) |=> (dirty_vec != '0));

    // R5
    hit_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !cmd_valid) |=> (touched_vec != '0));

    // R4
    perm_no_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_perm && !cmd_valid) |=> ($stable(touched_vec) && $stable(dirty_vec)));
endmodule

bind xlate_cache xc_cache_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_valid    (lk_valid),
    .lk_write    (lk_write),
    .hit         (hit),
    .fault_miss  (fault_miss),
    .fault_perm  (fault_perm),
    .cmd_valid   (cmd_valid),
    .priv_mode   (priv_mode),
    .cmd_op      (cmd_op),
    .valid_vec   (valid_vec),
    .touched_vec (touched_vec),
    .dirty_vec   (dirty_vec)
);

// File: tb/xlate_cache_bench.sv
`timescale 1ns/1ps
module xlate_cache_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0, lk_write = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  cur_pid = '0;
    logic        hit, fault_miss, fault_perm, hit_touched, hit_dirty, cmd_priv_fault;
    logic [31:0] paddr;
    logic        priv_mode = 1'b0, cmd_valid = 1'b0, cmd_rd = 1'b0, cmd_wr = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [2:0]  cmd_idx = '0;
    logic [19:0] cmd_vpn = '0, cmd_pfn = '0;
    logic [7:0]  cmd_pid = '0;

    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    xlate_cache u_xlate_cache (.*);

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // command: driven after a falling edge, committed on the next rising edge
    task automatic cmd(logic priv, logic [1:0] op, logic [2:0] idx, logic [19:0] vpn,
                       logic [19:0] pfn, logic [7:0] pid, logic rd, logic wr,
                       string req);
        @(negedge clk);
        priv_mode = priv; cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx;
        cmd_vpn = vpn; cmd_pfn = pfn; cmd_pid = pid; cmd_rd = rd; cmd_wr = wr;
        #1 chk(req, "cmd_priv_fault", 32'(cmd_priv_fault), 32'(!priv));
        @(negedge clk);
        cmd_valid = 1'b0; priv_mode = 1'b0;
    endtask

    // lookup: sampled 1 ns after the inputs settle, state updates on the next edge
    task automatic look(logic [31:0] va, logic wr, logic [7:0] pid, string req,
                        logic e_hit, logic e_miss, logic e_perm, logic [31:0] e_pa,
                        logic e_t, logic e_d);
        @(negedge clk);
        lk_valid = 1'b1; lk_write = wr; lk_vaddr = va; cur_pid = pid;
        #1;
        chk(req, "hit", 32'(hit), 32'(e_hit));
        chk(req, "fault_miss", 32'(fault_miss), 32'(e_miss));
        chk(req, "fault_perm", 32'(fault_perm), 32'(e_perm));
        if (e_hit) begin
            chk(req, "paddr", paddr, e_pa);
            chk(req, "hit_touched", 32'(hit_touched), 32'(e_t));
            chk(req, "hit_dirty", 32'(hit_dirty), 32'(e_d));
        end
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic t_reset;  // R12
        look(32'h0000_0000, 1'b0, 8'd0, "R12", 0, 1, 0, 0, 0, 0);
        look(32'h1234_5678, 1'b0, 8'd7, "R12", 0, 1, 0, 0, 0, 0);
    endtask

    task automatic t_basic;  // R8 R1 R5 R6
        cmd(1, 2'b00, 3'd2, 20'h12345, 20'hABCDE, 8'd7, 1, 1, "R8");
        look(32'h1234_5678, 0, 8'd7, "R1", 1, 0, 0, 32'hABCD_E678, 0, 0);
        look(32'h1234_5FFF, 0, 8'd7, "R5", 1, 0, 0, 32'hABCD_EFFF, 1, 0);
        look(32'h1234_5000, 1, 8'd7, "R6", 1, 0, 0, 32'hABCD_E000, 1, 0);
        look(32'h1234_5001, 0, 8'd7, "R6", 1, 0, 0, 32'hABCD_E001, 1, 1);
    endtask

    task automatic t_pid;  // R3 R2
        look(32'h1234_5678, 0, 8'd8, "R3", 0, 1, 0, 0, 0, 0);
        look(32'h1234_6678, 0, 8'd7, "R2", 0, 1, 0, 0, 0, 0);
    endtask

    task automatic t_perm;  // R4
        cmd(1, 2'b00, 3'd5, 20'h00400, 20'h00077, 8'd7, 1, 0, "R8");
        look(32'h0040_0010, 1, 8'd7, "R4", 0, 0, 1, 0, 0, 0);
        look(32'h0040_0010, 0, 8'd7, "R4", 1, 0, 0, 32'h0007_7010, 0, 0);
        cmd(1, 2'b00, 3'd6, 20'h00500, 20'h00088, 8'd7, 0, 1, "R8");
        look(32'h0050_0020, 0, 8'd7, "R4", 0, 0, 1, 0, 0, 0);
        look(32'h0050_0020, 1, 8'd7, "R4", 1, 0, 0, 32'h0008_8020, 0, 0);
    endtask

    task automatic t_user;  // R7
        cmd(0, 2'b00, 3'd3, 20'h00600, 20'h00099, 8'd7, 1, 1, "R7");
        look(32'h0060_0000, 0, 8'd7, "R7", 0, 1, 0, 0, 0, 0);
        cmd(0, 2'b10, 3'd0, 20'h0, 20'h0, 8'd0, 0, 0, "R7");
        look(32'h1234_5000, 0, 8'd7, "R7", 1, 0, 0, 32'hABCD_E000, 1, 1);
    endtask

    task automatic t_dup;  // R13 R9
        cmd(1, 2'b00, 3'd4, 20'h00700, 20'h22222, 8'd3, 1, 1, "R8");
        cmd(1, 2'b00, 3'd1, 20'h00700, 20'h11111, 8'd3, 1, 1, "R8");
        look(32'h0070_0ABC, 0, 8'd3, "R13", 1, 0, 0, 32'h1111_1ABC, 0, 0);
        cmd(1, 2'b01, 3'd1, 20'h0, 20'h0, 8'd0, 0, 0, "R9");
        look(32'h0070_0ABC, 0, 8'd3, "R9", 1, 0, 0, 32'h2222_2ABC, 0, 0);
        cmd(1, 2'b01, 3'd4, 20'h0, 20'h0, 8'd0, 0, 0, "R9");
        look(32'h0070_0ABC, 0, 8'd3, "R9", 0, 1, 0, 0, 0, 0);
        look(32'h1234_5000, 0, 8'd7, "R9", 1, 0, 0, 32'hABCD_E000, 1, 1);
    endtask

    task automatic t_clrt;  // R11
        cmd(1, 2'b11, 3'd0, 20'h0, 20'h0, 8'd0, 0, 0, "R11");
        look(32'h1234_5000, 0, 8'd7, "R11", 1, 0, 0, 32'hABCD_E000, 0, 1);
        look(32'h0040_0000, 0, 8'd7, "R11", 1, 0, 0, 32'h0007_7000, 0, 0);
    endtask

    task automatic t_flush;  // R10
        cmd(1, 2'b10, 3'd0, 20'h0, 20'h0, 8'd0, 0, 0, "R10");
        look(32'h1234_5000, 0, 8'd7, "R10", 0, 1, 0, 0, 0, 0);
        look(32'h0040_0000, 0, 8'd7, "R10", 0, 1, 0, 0, 0, 0);
        look(32'h0050_0000, 1, 8'd7, "R10", 0, 1, 0, 0, 0, 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                chk("R12", "hit idle", 32'(hit), 32'd0);
                chk("R7", "cmd_priv_fault idle", 32'(cmd_priv_fault), 32'd0);
                t_reset();
                t_basic();
                t_pid();
                t_perm();
                t_user();
                t_dup();
                t_clrt();
                t_flush();
            end
            begin
                repeat (200000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule